// File: doc/BRIEF.md
# Compressed Memory Sector Usage Monitor

The block keeps a running total of the 256-byte physical sectors held by compressed data. Each cached line of 1 KB occupies between zero and four sectors once compressed. A line that compresses to almost nothing lives entirely in its translation entry and occupies no sector. Whenever a line is written back, the line controller presents the sector count the line held before and the count it holds now. The monitor applies the difference to its total in a single cycle. The total is clamped to a programmable capacity, and it never drops below zero. An attempt to go below zero is recorded in a sticky error flag.

Software reads the total through a small register port. The same port programs an upper and a lower watermark and the pool capacity. When usage reaches the upper watermark, the block raises a warning interrupt, so that the operating system can free or zero pages before the physical pool runs out. The interrupt is sticky. A write-one-to-clear removes it only once usage has fallen below the lower watermark, which gives hysteresis between the two levels.

Top module: `sector_pool_monitor`

## Requirements
- R1: After reset, usage reads 0, the warning interrupt and the error flag are low, the upper watermark reads MAX_SECTORS-MAX_SECTORS/8, the lower watermark reads MAX_SECTORS-MAX_SECTORS/4 and the capacity reads MAX_SECTORS.
- R2: A cycle with wb_valid high changes usage by wb_new_sectors minus wb_old_sectors, visible in the next cycle. A read issued with reg_ren returns the addressed register on reg_rdata one cycle later, with reg_rvalid high in that cycle. The register addresses are: 0 usage, 1 upper watermark, 2 lower watermark, 3 capacity, 4 status.
- R3: Usage never exceeds the programmed capacity. A result above the capacity is stored as the capacity.
- R4: A writeback whose result would be negative stores 0 and sets the sticky error flag. Writing status (address 4) with bit 1 set clears the flag.
- R5: The warning interrupt rises in the cycle after usage is at or above the upper watermark.
- R6: Writing status with bit 0 set clears the interrupt only when usage is below the lower watermark. Otherwise the write is ignored and the interrupt stays high. Dropping below the lower watermark without such a write leaves the interrupt high.
- R7: A write to the usage address has no effect on usage.
- R8: A capacity write above MAX_SECTORS stores MAX_SECTORS. Watermark writes read back as written.
- R9: A writeback to a line that now has no sectors (new count 0) releases all of its old sectors. A writeback of 0 in place of 0 leaves usage unchanged.
- R10: Status reads as bit 0 for the interrupt and bit 1 for the error flag, with the other bits zero. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 1 | A line writeback is presented this cycle |
| wb_old_sectors | input | LINE_W (3) | Sectors the line held before the writeback (0..4) |
| wb_new_sectors | input | LINE_W (3) | Sectors the line holds after the writeback (0..4) |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| reg_rvalid | output | 1 | reg_rdata holds the result of the previous read |
| warn_irq | output | 1 | Sticky pool-exhaustion warning interrupt |
| underflow_err | output | 1 | Sticky attempted-underflow flag |

## Verification
The assertions assume that every writeback carries old and new counts no larger than four sectors. They also assume that software keeps the lower watermark at or below the upper one, because the hysteresis checks mean nothing when the two are inverted. The stimulus draws per-line counts only from 0 to 4. It programs the watermarks at 60 and 80 against a capacity of 100 before it drives any traffic. The random phase lets usage hit the floor and the ceiling often, and it interleaves clear requests at random levels, so that both the accepted and the refused clears occur.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef enum logic [2:0] {
    ADR_USAGE = 3'd0,
    ADR_HIGH  = 3'd1,
    ADR_LOW   = 3'd2,
    ADR_CAP   = 3'd3,
    ADR_STAT  = 3'd4
  } spm_addr_e;

  localparam int STAT_IRQ_BIT = 0;
  localparam int STAT_ERR_BIT = 1;

endpackage

// File: rtl/spm_usage_acc.sv
module spm_usage_acc #(
  parameter int CNT_W        = 16,
  parameter int LINE_W       = 3,
  parameter int LINE_SECTORS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_valid,
  input  logic [LINE_W-1:0] wb_old,
  input  logic [LINE_W-1:0] wb_new,
  input  logic [CNT_W-1:0]  cap,
  input  logic              err_clr,
  output logic [CNT_W-1:0]  usage_q,
  output logic              err_q
);

  localparam int EXT_W = CNT_W + 1;

  logic [LINE_W-1:0] add_n, sub_n;
  logic [EXT_W-1:0]  grow, net;
  logic              under;
  logic [CNT_W-1:0]  usage_d;
  logic              err_d;

  always_comb begin
    add_n = wb_valid ? wb_new : '0;
    sub_n = wb_valid ? wb_old : '0;
    grow  = {1'b0, usage_q} + EXT_W'(add_n);
    under = grow < EXT_W'(sub_n);
    net   = grow - EXT_W'(sub_n);
    if (under)
      usage_d = '0;
    else if (net > {1'b0, cap})
      usage_d = cap;
    else
      usage_d = net[CNT_W-1:0];
    err_d = under | (err_q & ~err_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      usage_q <= '0;
      err_q   <= 1'b0;
    end else begin
      usage_q <= usage_d;
      err_q   <= err_d;
    end
  end

  // Input contract: per-line counts stay within one line's sector span.
  assert_line_range_R2: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (int'(wb_old) <= LINE_SECTORS && int'(wb_new) <= LINE_SECTORS));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> usage_q <= $past(cap));

  assert_underflow_sets_err_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && (({1'b0, usage_q} + EXT_W'(wb_new)) < EXT_W'(wb_old)))
      |=> (err_q && usage_q == '0));

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);

endmodule

// File: rtl/spm_watermark.sv
module spm_watermark #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] usage,
  input  logic [CNT_W-1:0] high_mark,
  input  logic [CNT_W-1:0] low_mark,
  input  logic             clr_req,
  output logic             irq_q
);

  logic at_high, below_low, irq_d;

  always_comb begin
    at_high   = usage >= high_mark;
    below_low = usage < low_mark;
    irq_d     = at_high | (irq_q & ~(clr_req & below_low));
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end

  assert_irq_set_R5: assert property (@(posedge clk) disable iff (rst)
    (usage >= high_mark) |=> irq_q);

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !(clr_req && usage < low_mark)) |=> irq_q);

  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_req && usage < low_mark && usage < high_mark) |=> !irq_q);

endmodule

// File: rtl/spm_regs.sv
module spm_regs
  import spm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 32,
  parameter int MAX_SECTORS = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen,
  input  logic              ren,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  usage,
  input  logic              irq,
  input  logic              err,
  output logic [CNT_W-1:0]  high_q,
  output logic [CNT_W-1:0]  low_q,
  output logic [CNT_W-1:0]  cap_q,
  output logic              irq_clr,
  output logic              err_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam logic [CNT_W-1:0]  HIGH_RST = CNT_W'(MAX_SECTORS - MAX_SECTORS / 8);
  localparam logic [CNT_W-1:0]  LOW_RST  = CNT_W'(MAX_SECTORS - MAX_SECTORS / 4);
  localparam logic [CNT_W-1:0]  CAP_RST  = CNT_W'(MAX_SECTORS);
  localparam logic [DATA_W-1:0] CAP_LIM  = DATA_W'(MAX_SECTORS);

  logic              wr_stat;
  logic [CNT_W-1:0]  cap_wr;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_stat = wen && (addr == ADR_STAT);
    irq_clr = wr_stat && wdata[STAT_IRQ_BIT];
    err_clr = wr_stat && wdata[STAT_ERR_BIT];
    cap_wr  = (wdata > CAP_LIM) ? CAP_RST : wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      high_q <= HIGH_RST;
      low_q  <= LOW_RST;
      cap_q  <= CAP_RST;
    end else if (wen) begin
      case (addr)
        ADR_HIGH: high_q <= wdata[CNT_W-1:0];
        ADR_LOW:  low_q  <= wdata[CNT_W-1:0];
        ADR_CAP:  cap_q  <= cap_wr;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_USAGE: rd_mux = DATA_W'(usage);
      ADR_HIGH:  rd_mux = DATA_W'(high_q);
      ADR_LOW:   rd_mux = DATA_W'(low_q);
      ADR_CAP:   rd_mux = DATA_W'(cap_q);
      ADR_STAT: begin
        rd_mux[STAT_IRQ_BIT] = irq;
        rd_mux[STAT_ERR_BIT] = err;
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= ren;
      if (ren) rdata <= rd_mux;
    end
  end

  assert_cap_limit_R8: assert property (@(posedge clk) disable iff (rst)
    cap_q <= CAP_RST);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    ren |=> rvalid);

endmodule

// File: rtl/sector_pool_monitor.sv
module sector_pool_monitor #(
  parameter int MAX_SECTORS  = 32768,
  parameter int LINE_SECTORS = 4,
  parameter int DATA_W       = 32,
  localparam int CNT_W       = $clog2(MAX_SECTORS + 1),
  localparam int LINE_W      = $clog2(LINE_SECTORS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_valid,
  input  logic [LINE_W-1:0] wb_old_sectors,
  input  logic [LINE_W-1:0] wb_new_sectors,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              warn_irq,
  output logic              underflow_err
);

  logic [CNT_W-1:0] usage_q, high_q, low_q, cap_q;
  logic             irq_clr, err_clr;

  spm_usage_acc #(
    .CNT_W(CNT_W), .LINE_W(LINE_W), .LINE_SECTORS(LINE_SECTORS)
  ) u_acc (
    .clk(clk), .rst(rst),
    .wb_valid(wb_valid), .wb_old(wb_old_sectors), .wb_new(wb_new_sectors),
    .cap(cap_q), .err_clr(err_clr),
    .usage_q(usage_q), .err_q(underflow_err)
  );

  spm_watermark #(.CNT_W(CNT_W)) u_mark (
    .clk(clk), .rst(rst),
    .usage(usage_q), .high_mark(high_q), .low_mark(low_q),
    .clr_req(irq_clr), .irq_q(warn_irq)
  );

  spm_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .MAX_SECTORS(MAX_SECTORS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wen(reg_wen), .ren(reg_ren), .addr(reg_addr), .wdata(reg_wdata),
    .usage(usage_q), .irq(warn_irq), .err(underflow_err),
    .high_q(high_q), .low_q(low_q), .cap_q(cap_q),
    .irq_clr(irq_clr), .err_clr(err_clr),
    .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

endmodule

// File: tb/test_sector_pool_monitor.sv
module test_sector_pool_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 32768;
  localparam int CAP = 100, HI = 80, LO = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wb_valid = 1'b0;
  logic [2:0]  wb_old_sectors = '0, wb_new_sectors = '0;
  logic        reg_wen = 1'b0, reg_ren = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid, warn_irq, underflow_err;

  sector_pool_monitor i_sector_pool_monitor (
    .clk(clk), .rst(rst), .wb_valid(wb_valid),
    .wb_old_sectors(wb_old_sectors), .wb_new_sectors(wb_new_sectors),
    .reg_wen(reg_wen), .reg_ren(reg_ren), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .warn_irq(warn_irq), .underflow_err(underflow_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  int    q_exp[$];
  string q_tag[$];
  int    mu = 0, cap_m = MAXS, hi_m = MAXS - MAXS / 8, lo_m = MAXS - MAXS / 4;
  bit    mirq = 0, merr = 0;
  bit    done = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read results as the design returns them.
  initial begin
    forever begin
      @(negedge clk);
      if (reg_rvalid) begin
        if (q_exp.size() == 0) check("R2 unexpected rvalid", 1, 0);
        else check(q_tag.pop_front(), int'(reg_rdata), q_exp.pop_front());
      end
    end
  end

  task automatic rd(int a, int exp, string tag);
    reg_ren = 1'b1; reg_addr = 3'(a);
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    reg_ren = 1'b0;
  endtask

  task automatic wr(int a, int d);
    reg_wen = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
    if (a == 4) begin
      if (d[0] && mu < lo_m) mirq = 0;
      if (d[1]) merr = 0;
    end
    @(negedge clk);
    reg_wen = 1'b0;
    @(negedge clk);
  endtask

  task automatic wb(int o, int n);
    int s;
    wb_valid = 1'b1; wb_old_sectors = 3'(o); wb_new_sectors = 3'(n);
    s = mu + n - o;
    if (s < 0) begin mu = 0; merr = 1; end
    else if (s > cap_m) mu = cap_m;
    else mu = s;
    @(negedge clk);
    wb_valid = 1'b0;
    if (mu >= hi_m) mirq = 1;
    @(negedge clk);
  endtask

  task automatic pins(string tag);
    check({tag, " irq"}, int'(warn_irq), int'(mirq));
    check({tag, " err"}, int'(underflow_err), int'(merr));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    pins("R1");
    rd(0, 0, "R1 usage");
    rd(1, MAXS - MAXS / 8, "R1 high");
    rd(2, MAXS - MAXS / 4, "R1 low");
    rd(3, MAXS, "R1 cap");
    rd(4, 0, "R1 status");
    // R8 programming and capacity clamp
    wr(1, HI); hi_m = HI;
    wr(2, LO); lo_m = LO;
    wr(3, MAXS + 5);
    rd(3, MAXS, "R8 cap clamp");
    wr(3, CAP); cap_m = CAP;
    rd(1, HI, "R8 high");
    rd(2, LO, "R8 low");
    rd(3, CAP, "R8 cap");
    // R2 signed deltas
    for (int i = 0; i < 5; i++) wb(0, 4);
    rd(0, 20, "R2 grow");
    wb(4, 1);
    rd(0, 17, "R2 shrink");
    // R9 trivial lines
    wb(3, 0);
    rd(0, 14, "R9 release");
    wb(0, 0);
    rd(0, 14, "R9 zero for zero");
    // R7 usage write ignored
    wr(0, 55);
    rd(0, 14, "R7 usage write");
    // R5 interrupt at high mark
    for (int i = 0; i < 16; i++) wb(0, 4);
    check("R5 below high", int'(warn_irq), 0);
    wb(0, 4);
    pins("R5");
    rd(4, 1, "R5 status");
    // R3 saturation
    for (int i = 0; i < 10; i++) wb(0, 4);
    rd(0, CAP, "R3 saturate");
    // R6 refused clear, then sticky below low, then accepted clear
    wr(4, 1);
    pins("R6 refused");
    for (int i = 0; i < 11; i++) wb(4, 0);
    rd(0, 56, "R6 level");
    pins("R6 sticky");
    wr(4, 1);
    pins("R6 cleared");
    check("R6 irq low", int'(warn_irq), 0);
    // R4 underflow
    for (int i = 0; i < 14; i++) wb(4, 0);
    check("R4 no err yet", int'(underflow_err), 0);
    wb(4, 0);
    pins("R4");
    rd(0, 0, "R4 floor");
    rd(4, 2, "R10 status err");
    wr(4, 2);
    pins("R4 err clear");
    // R10 unused addresses
    rd(5, 0, "R10 addr5");
    rd(6, 0, "R10 addr6");
    rd(7, 0, "R10 addr7");
    // Random writeback stream against the reference model (R2 R3 R4 R5 R6)
    for (int i = 0; i < 400; i++) begin
      int o, n;
      o = $urandom_range(0, 4);
      n = (mu < 30) ? $urandom_range(2, 4) : $urandom_range(0, 4);
      if (i % 100 > 60) n = $urandom_range(0, 2);
      wb(o, n);
      rd(0, mu, "R2 random usage");
      pins("R5 random");
      if ($urandom_range(0, 7) == 0) begin
        wr(4, int'($urandom_range(1, 3)));
        pins("R6 random clear");
      end
    end
    rd(4, (int'(merr) << 1) | int'(mirq), "R10 final status");
    repeat (4) @(negedge clk);
    check("R2 queue drained", q_exp.size(), 0);
    finish_run();
  end

endmodule